// File: doc/BRIEF.md
# Quad multiply add-subtract sum

This block is a four-lane arithmetic slice. Each lane multiplies an A operand of `A_W` bits by a B operand of `B_W` bits. Lanes 0 and 1 form one pair and lanes 2 and 3 form another. In each pair the second product is added to or subtracted from the first, under a separate control bit for each pair. The two pair results are then added into a single sum. Each stage grows the result by one bit, so the output is `A_W+B_W+2` bits wide and never loses a carry or a borrow.

Three kinds of optional register sit along the path: A and B input registers, pipeline registers after the multipliers, and an output register after the final adder. Parameters enable or bypass each kind on its own and give each one a choice among four clock-enable/reset control sets. Two control bits choose two's-complement or unsigned treatment of the A operands and of the B operands. These bits and the add/subtract bits travel in the register stages with the operands. Each input lane can also take its operand from the lane below it instead of from its own input, so operands can be shifted through the input registers and on to a neighbouring slice.

Top module: `qmas_top`

## Requirements
- R1: `y_o` equals p0 + p1 + p2 + p3 modulo 2^(A_W+B_W+2), where pk is the product of lane k (lane k uses bits [k*W +: W] of `a_i` and `b_i`). p1 is negated when `sub_i[0]`=1 and p3 is negated when `sub_i[1]`=1. A value of 0 adds.
- R2: When `sign_a_i`=1 every A operand is read as two's complement, and when it is 0 as unsigned. `sign_b_i` does the same for the B operands.
- R3: At every growth step the result is sign-extended if it can be negative and zero-extended otherwise. No value that fits in the output width is ever wrapped. This includes all-unsigned extremes and unsigned subtraction.
- R4: The latency from operands to `y_o` equals the number of enabled stage kinds along the path. It is 3 with all stages enabled and 0 (combinational) with all stages bypassed.
- R5: While the clock-enable bit of a stage's control set is 0, that stage's registers hold their value. With every enable low, `y_o` stays constant.
- R6: A high reset bit of a control set clears the registers of the stages that use that set to zero on the next clock edge. This happens even when the set's enable bit is low.
- R7: Resetting one control set leaves the registers of the other sets untouched. A reset of the A input set gives a single zero result, three stages later.
- R8: The sign and add/subtract controls are captured together with the operands they arrive with. A control change therefore applies to exactly the sample presented in the same cycle.
- R9: With cascading enabled, input lane k takes its operand from lane k-1's input register, and lane 0 takes it from `sra_i`/`srb_i`. `sra_o`/`srb_o` give lane 3's input register output, which is the shifted-in value delayed by 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all register stages |
| ce_i | input | 4 | Clock enable of control sets 0..3 |
| rst_i | input | 4 | Synchronous active-high reset of control sets 0..3 |
| a_i | input | 4*A_W | A operands, lane k at [k*A_W +: A_W] |
| b_i | input | 4*B_W | B operands, lane k at [k*B_W +: B_W] |
| sign_a_i | input | 1 | 1 = A operands are two's complement |
| sign_b_i | input | 1 | 1 = B operands are two's complement |
| sub_i | input | 2 | Bit k = 1 subtracts the second product of pair k |
| sra_i | input | A_W | A cascade shift input into lane 0 |
| srb_i | input | B_W | B cascade shift input into lane 0 |
| sra_o | output | A_W | A cascade shift output from lane 3 |
| srb_o | output | B_W | B cascade shift output from lane 3 |
| y_o | output | A_W+B_W+2 | Final sum |

## Verification
The hardest case to reach from the ports is a reset of one control set while the other sets keep running. Its effect shows only as a single zero result that surfaces stages later, between correct results. The bench holds a constant nonzero operand set, pulses only the A input set's reset, and checks the result in each cycle before, during and after the zero sample. Arithmetic corners are covered by a full sweep over 3-bit lanes with every combination of signedness and add/subtract, run on a bypassed instance. A cascading instance shifts a numbered sequence through the input registers and compares both the chain output and the sum against bench-side history.

// File: rtl/qmas_pkg.sv
package qmas_pkg;
    localparam int NLANE = 4;
    localparam int NSET  = 4;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } qmas_op_e;

    // controls that travel with the products through the pipeline stage
    typedef struct packed {
        logic       sgn_a;
        logic       sgn_b;
        logic [1:0] sub;
    } qmas_ctrl_t;

    localparam int CTRL_W = $bits(qmas_ctrl_t);
endpackage

// File: rtl/qmas_stage.sv
// Optional register: present when EN != 0, a wire otherwise.
module qmas_stage #(
    parameter int W   = 8,
    parameter int EN  = 1,
    parameter int SET = 0
) (
    input  logic                     clk,
    input  logic [qmas_pkg::NSET-1:0] ce_i,
    input  logic [qmas_pkg::NSET-1:0] rst_i,
    input  logic [W-1:0]             d_i,
    output logic [W-1:0]             q_o
);
    generate
        if (EN != 0) begin : g_reg
            logic [W-1:0] q_r;
            always_ff @(posedge clk) begin
                if (rst_i[SET])
                    q_r <= '0;
                else if (ce_i[SET])
                    q_r <= d_i;
            end
            assign q_o = q_r;
        end else begin : g_byp
            assign q_o = d_i;
        end
    endgenerate
endmodule

// File: rtl/qmas_mul.sv
// Multiplier with per-operand sign handling. The product is exact in A_W+B_W bits.
module qmas_mul #(
    parameter int A_W = 8,
    parameter int B_W = 8
) (
    input  logic [A_W-1:0]     a_i,
    input  logic [B_W-1:0]     b_i,
    input  logic               sa_i,
    input  logic               sb_i,
    output logic [A_W+B_W-1:0] p_o
);
    localparam int P_W = A_W + B_W;

    logic [P_W-1:0] a_x;
    logic [P_W-1:0] b_x;

    assign a_x = {{(P_W-A_W){sa_i & a_i[A_W-1]}}, a_i};
    assign b_x = {{(P_W-B_W){sb_i & b_i[B_W-1]}}, b_i};
    assign p_o = a_x * b_x;
endmodule

// File: rtl/qmas_addsub.sv
// One-bit-growth adder/subtractor; each operand is extended by its own flag.
module qmas_addsub #(
    parameter int W = 16
) (
    input  logic              [W-1:0] x_i,
    input  logic              [W-1:0] y_i,
    input  logic                      sx_i,
    input  logic                      sy_i,
    input  qmas_pkg::qmas_op_e        op_i,
    output logic              [W:0]   r_o
);
    logic [W:0] x_e;
    logic [W:0] y_e;

    assign x_e = {sx_i & x_i[W-1], x_i};
    assign y_e = {sy_i & y_i[W-1], y_i};

    always_comb begin
        if (op_i == qmas_pkg::OP_SUB)
            r_o = x_e - y_e;
        else
            r_o = x_e + y_e;
    end
endmodule

// File: rtl/qmas_top.sv
module qmas_top
    import qmas_pkg::*;
#(
    parameter int         A_W      = 8,
    parameter int         B_W      = 8,
    parameter int         A_IN_EN  = 1,
    parameter int         A_IN_SET = 0,
    parameter int         B_IN_EN  = 1,
    parameter int         B_IN_SET = 1,
    parameter int         PIPE_EN  = 1,
    parameter int         PIPE_SET = 2,
    parameter int         OUT_EN   = 1,
    parameter int         OUT_SET  = 3,
    parameter logic [3:0] A_CASC   = 4'b0000,
    parameter logic [3:0] B_CASC   = 4'b0000,
    localparam int        P_W      = A_W + B_W,
    localparam int        Y_W      = P_W + 2
) (
    input  logic                   clk,
    input  logic [NSET-1:0]        ce_i,
    input  logic [NSET-1:0]        rst_i,
    input  logic [NLANE*A_W-1:0]   a_i,
    input  logic [NLANE*B_W-1:0]   b_i,
    input  logic                   sign_a_i,
    input  logic                   sign_b_i,
    input  logic [1:0]             sub_i,
    input  logic [A_W-1:0]         sra_i,
    input  logic [B_W-1:0]         srb_i,
    output logic [A_W-1:0]         sra_o,
    output logic [B_W-1:0]         srb_o,
    output logic [Y_W-1:0]         y_o
);
    logic [A_W-1:0] a_src [NLANE];
    logic [A_W-1:0] a_q   [NLANE];
    logic [B_W-1:0] b_src [NLANE];
    logic [B_W-1:0] b_q   [NLANE];
    logic [P_W-1:0] p_d   [NLANE];
    logic [P_W-1:0] p_q   [NLANE];

    // control bits captured with the A and B operands
    logic [2:0] a_ctl_q;
    logic       b_ctl_q;
    qmas_ctrl_t ctl_d;
    qmas_ctrl_t ctl_q;

    qmas_stage #(.W(3), .EN(A_IN_EN), .SET(A_IN_SET)) u_actl (
        .clk(clk), .ce_i(ce_i), .rst_i(rst_i),
        .d_i({sign_a_i, sub_i}), .q_o(a_ctl_q)
    );
    qmas_stage #(.W(1), .EN(B_IN_EN), .SET(B_IN_SET)) u_bctl (
        .clk(clk), .ce_i(ce_i), .rst_i(rst_i),
        .d_i(sign_b_i), .q_o(b_ctl_q)
    );

    // input stages with optional cascade source per lane
    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        if (A_CASC[k]) begin : g_acas
            if (k == 0) begin : g_first
                assign a_src[k] = sra_i;
            end else begin : g_next
                assign a_src[k] = a_q[k-1];
            end
        end else begin : g_apar
            assign a_src[k] = a_i[k*A_W +: A_W];
        end

        if (B_CASC[k]) begin : g_bcas
            if (k == 0) begin : g_first
                assign b_src[k] = srb_i;
            end else begin : g_next
                assign b_src[k] = b_q[k-1];
            end
        end else begin : g_bpar
            assign b_src[k] = b_i[k*B_W +: B_W];
        end

        qmas_stage #(.W(A_W), .EN(A_IN_EN), .SET(A_IN_SET)) u_areg (
            .clk(clk), .ce_i(ce_i), .rst_i(rst_i),
            .d_i(a_src[k]), .q_o(a_q[k])
        );
        qmas_stage #(.W(B_W), .EN(B_IN_EN), .SET(B_IN_SET)) u_breg (
            .clk(clk), .ce_i(ce_i), .rst_i(rst_i),
            .d_i(b_src[k]), .q_o(b_q[k])
        );

        qmas_mul #(.A_W(A_W), .B_W(B_W)) u_mul (
            .a_i(a_q[k]), .b_i(b_q[k]),
            .sa_i(a_ctl_q[2]), .sb_i(b_ctl_q),
            .p_o(p_d[k])
        );

        qmas_stage #(.W(P_W), .EN(PIPE_EN), .SET(PIPE_SET)) u_preg (
            .clk(clk), .ce_i(ce_i), .rst_i(rst_i),
            .d_i(p_d[k]), .q_o(p_q[k])
        );
    end

    assign sra_o = a_q[NLANE-1];
    assign srb_o = b_q[NLANE-1];

    assign ctl_d.sgn_a = a_ctl_q[2];
    assign ctl_d.sgn_b = b_ctl_q;
    assign ctl_d.sub   = a_ctl_q[1:0];

    qmas_stage #(.W(CTRL_W), .EN(PIPE_EN), .SET(PIPE_SET)) u_cpipe (
        .clk(clk), .ce_i(ce_i), .rst_i(rst_i),
        .d_i(ctl_d), .q_o(ctl_q)
    );

    // pair stage and final summation
    logic           prod_sgn;
    logic [P_W:0]   pair0;
    logic [P_W:0]   pair1;
    logic [Y_W-1:0] sum_d;
    qmas_op_e       op0;
    qmas_op_e       op1;

    assign prod_sgn = ctl_q.sgn_a | ctl_q.sgn_b;
    assign op0      = qmas_op_e'(ctl_q.sub[0]);
    assign op1      = qmas_op_e'(ctl_q.sub[1]);

    qmas_addsub #(.W(P_W)) u_pair0 (
        .x_i(p_q[0]), .y_i(p_q[1]), .sx_i(prod_sgn), .sy_i(prod_sgn),
        .op_i(op0), .r_o(pair0)
    );
    qmas_addsub #(.W(P_W)) u_pair1 (
        .x_i(p_q[2]), .y_i(p_q[3]), .sx_i(prod_sgn), .sy_i(prod_sgn),
        .op_i(op1), .r_o(pair1)
    );
    // a pair result can be negative when signed or when it subtracts
    qmas_addsub #(.W(P_W+1)) u_final (
        .x_i(pair0), .y_i(pair1),
        .sx_i(prod_sgn | ctl_q.sub[0]), .sy_i(prod_sgn | ctl_q.sub[1]),
        .op_i(OP_ADD), .r_o(sum_d)
    );

    qmas_stage #(.W(Y_W), .EN(OUT_EN), .SET(OUT_SET)) u_oreg (
        .clk(clk), .ce_i(ce_i), .rst_i(rst_i),
        .d_i(sum_d), .q_o(y_o)
    );
endmodule

// File: rtl/qmas_chk.sv
module qmas_chk #(
    parameter int         A_W      = 8,
    parameter int         OUT_EN   = 1,
    parameter int         OUT_SET  = 3,
    parameter int         A_IN_EN  = 1,
    parameter int         A_IN_SET = 0,
    parameter logic [3:0] A_CASC   = 4'b0000,
    parameter int         Y_W      = 18
) (
    input logic           clk,
    input logic [3:0]     ce_i,
    input logic [3:0]     rst_i,
    input logic [Y_W-1:0] y_o,
    input logic [Y_W-1:0] sum_d,
    input logic [A_W-1:0] sra_o,
    input logic [A_W-1:0] a_q2
);
    logic armed = 1'b0;
    always_ff @(posedge clk)
        if (&rst_i) armed <= 1'b1;

    // R4: an enabled output register loads the sum one edge later
    assert_out_load_R4: assert property (@(posedge clk) disable iff (!armed)
        (OUT_EN != 0 && ce_i[OUT_SET] && !rst_i[OUT_SET]) |=> (y_o == $past(sum_d)));

    // R5: a low enable holds the output register
    assert_out_hold_R5: assert property (@(posedge clk) disable iff (!armed)
        (OUT_EN != 0 && !ce_i[OUT_SET] && !rst_i[OUT_SET]) |=> $stable(y_o));

    // R6: reset clears the output register regardless of enable
    assert_out_clear_R6: assert property (@(posedge clk) disable iff (!armed)
        (OUT_EN != 0 && rst_i[OUT_SET]) |=> (y_o == '0));

    // R9: the chain output is lane 2's A register one edge earlier
    assert_casc_shift_R9: assert property (@(posedge clk) disable iff (!armed)
        (A_IN_EN != 0 && A_CASC[3] && ce_i[A_IN_SET] && !rst_i[A_IN_SET])
        |=> (sra_o == $past(a_q2)));
endmodule

bind qmas_top qmas_chk #(
    .A_W(A_W), .OUT_EN(OUT_EN), .OUT_SET(OUT_SET),
    .A_IN_EN(A_IN_EN), .A_IN_SET(A_IN_SET), .A_CASC(A_CASC), .Y_W(Y_W)
) u_chk (
    .clk(clk), .ce_i(ce_i), .rst_i(rst_i), .y_o(y_o), .sum_d(sum_d),
    .sra_o(sra_o), .a_q2(a_q[2])
);

// File: tb/qmas_top_tb.sv
module qmas_top_tb;
    localparam int W  = 3;
    localparam int YW = 2 * W + 2;

    logic          clk = 1'b0;
    logic [3:0]    ce, rst;
    logic [4*W-1:0] a, b;
    logic          sa, sb;
    logic [1:0]    sub;
    logic [W-1:0]  sra, srb;
    logic [W-1:0]  sra_f, srb_f, sra_b, srb_b, sra_c, srb_c;
    logic [YW-1:0] y_f, y_b, y_c;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    qmas_top #(.A_W(W), .B_W(W)) u_dut (
        .clk(clk), .ce_i(ce), .rst_i(rst), .a_i(a), .b_i(b),
        .sign_a_i(sa), .sign_b_i(sb), .sub_i(sub), .sra_i(sra), .srb_i(srb),
        .sra_o(sra_f), .srb_o(srb_f), .y_o(y_f)
    );
    qmas_top #(.A_W(W), .B_W(W), .A_IN_EN(0), .B_IN_EN(0), .PIPE_EN(0), .OUT_EN(0)) u_dut_byp (
        .clk(clk), .ce_i(ce), .rst_i(rst), .a_i(a), .b_i(b),
        .sign_a_i(sa), .sign_b_i(sb), .sub_i(sub), .sra_i(sra), .srb_i(srb),
        .sra_o(sra_b), .srb_o(srb_b), .y_o(y_b)
    );
    qmas_top #(.A_W(W), .B_W(W), .PIPE_EN(0), .OUT_EN(0),
               .A_CASC(4'b1111), .B_CASC(4'b1111)) u_dut_casc (
        .clk(clk), .ce_i(ce), .rst_i(rst), .a_i(a), .b_i(b),
        .sign_a_i(sa), .sign_b_i(sb), .sub_i(sub), .sra_i(sra), .srb_i(srb),
        .sra_o(sra_c), .srb_o(srb_c), .y_o(y_c)
    );

    function automatic int lane_val(logic [W-1:0] v, logic s);
        int r = int'(v);
        if (s && v[W-1]) r -= (1 << W);
        return r;
    endfunction

    function automatic logic [YW-1:0] model(logic [4*W-1:0] av, logic [4*W-1:0] bv,
                                            logic s_a, logic s_b, logic [1:0] sb2);
        int acc = 0;
        logic [31:0] t;
        for (int k = 0; k < 4; k++) begin
            int p = lane_val(av[k*W +: W], s_a) * lane_val(bv[k*W +: W], s_b);
            if ((k == 1 && sb2[0]) || (k == 3 && sb2[1])) acc -= p;
            else acc += p;
        end
        t = acc;
        return t[YW-1:0];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    logic [YW-1:0] exp_hist [200];
    logic [W-1:0]  ah [64];
    logic [W-1:0]  bh [64];
    logic [31:0]   seed;
    logic [YW-1:0] hold_y;
    logic [YW-1:0] ev;

    initial begin
        ce = 4'hF; rst = 4'hF; a = '0; b = '0; sa = 0; sb = 0; sub = 0;
        sra = '0; srb = '0; seed = 32'h1234_5678;
        repeat (2) @(negedge clk);
        // reset state
        chk("R6 reset y", 32'(y_f), 0);
        chk("R6 reset chain", 32'(sra_c), 0);

        // R1 R2 R3: full sweep on the bypassed instance (R4 zero latency)
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                for (int m = 0; m < 16; m++) begin
                    logic [W-1:0] iv, jv;
                    iv = W'(i); jv = W'(j);
                    a = {~jv, iv + jv, jv, iv};
                    b = {iv, 3'(7 - i), iv ^ 3'd5, jv};
                    sa = m[0]; sb = m[1]; sub = m[3:2];
                    #1;
                    chk("R1 R2 R3 R4 comb sum", 32'(y_b), 32'(model(a, b, sa, sb, sub)));
                end
        // unsigned extremes and unsigned subtraction (R3)
        a = '1; b = '1; sa = 0; sb = 0; sub = 2'b00; #1;
        chk("R3 unsigned max", 32'(y_b), 32'(8'd196));
        a = {3'd0, 3'd7, 3'd0, 3'd7}; b = {3'd0, 3'd7, 3'd0, 3'd7}; sub = 2'b00; #1;
        chk("R3 two pair max", 32'(y_b), 32'(8'd98));
        a = {3'd7, 3'd0, 3'd7, 3'd0}; sub = 2'b11; #1;
        chk("R3 unsigned borrow", 32'(y_b), 32'(model(a, b, 0, 0, 2'b11)));

        // R4 R8: streaming through the fully registered instance
        @(negedge clk);
        rst = 4'h0;
        for (int t = 0; t < 200; t++) begin
            if (t >= 3) chk("R4 R8 pipelined sum", 32'(y_f), 32'(exp_hist[t-3]));
            seed = seed * 32'd1103515245 + 32'd12345;
            a = seed[27:16]; b = seed[15:4];
            sa = seed[30]; sb = seed[29]; sub = seed[2:1];
            exp_hist[t] = model(a, b, sa, sb, sub);
            @(negedge clk);
        end

        // R5: all enables low freeze the output
        hold_y = y_f;
        ce = 4'h0;
        for (int t = 0; t < 4; t++) begin
            a = ~a; sub = ~sub;
            @(negedge clk);
            chk("R5 hold", 32'(y_f), 32'(hold_y));
        end
        ce = 4'hF;

        // R6 R7: pulse only the A input set reset
        a = {3'd3, 3'd5, 3'd2, 3'd6}; b = {3'd4, 3'd1, 3'd7, 3'd3};
        sa = 0; sb = 0; sub = 2'b00;
        ev = model(a, b, 0, 0, 2'b00);
        repeat (4) @(negedge clk);
        chk("R7 steady", 32'(y_f), 32'(ev));
        rst = 4'b0001;
        @(negedge clk);
        rst = 4'b0000;
        chk("R7 other sets unaffected", 32'(y_f), 32'(ev));
        @(negedge clk);
        chk("R7 still full", 32'(y_f), 32'(ev));
        @(negedge clk);
        chk("R6 R7 zero sample", 32'(y_f), 0);
        @(negedge clk);
        chk("R7 recovered", 32'(y_f), 32'(ev));

        // R6: output set reset with its enable low
        ce = 4'b0111; rst = 4'b1000;
        @(negedge clk);
        chk("R6 reset ignores enable", 32'(y_f), 0);
        rst = 4'b0000; ce = 4'hF;

        // R9: cascade chains on the cascading instance
        sa = 0; sb = 0; sub = 2'b00;
        for (int t = 0; t < 40; t++) begin
            if (t >= 4) begin
                logic [31:0] acc;
                acc = 0;
                chk("R9 A chain out", 32'(sra_c), 32'(ah[t-4]));
                chk("R9 B chain out", 32'(srb_c), 32'(bh[t-4]));
                for (int k = 0; k < 4; k++)
                    acc += 32'(ah[t-1-k]) * 32'(bh[t-1-k]);
                chk("R9 cascaded sum", 32'(y_c), 32'(acc[YW-1:0]));
            end
            ah[t] = W'(t * 3 + 1);
            bh[t] = W'(t * 5 + 2);
            sra = ah[t]; srb = bh[t];
            @(negedge clk);
        end

        finish_run();
    end
endmodule